// File: doc/BRIEF.md
# PLL Control Request Handshake Sequencer

This block runs the request/acknowledge exchange that makes a PLL's control interface pick up newly written settings. A one-cycle start pulse begins a handshake. The block first holds the request line low for a settle interval. It then raises the request and polls two acknowledge inputs, once every poll interval, up to a bounded number of polls. When polling ends it lowers the request again and pulses done. An error flag tells the caller whether the handshake succeeded or timed out.

All delays are counted in clock cycles and set by parameters. `SETTLE_CYC` sets the settle interval, `POLL_CYC` sets the poll interval and `MAX_POLLS` sets the poll limit. The acknowledges come from the PLL's own clock domain, so they pass through a two-flop synchronizer before they are sampled.

There is no data stream at this block's edge. Every pin is a plain control or status level or pulse, so none of them has back-pressure.

Top module: `pll_ctl_handshake`

## Requirements
- R1: After reset, `req_o`, `busy_o`, `done_o` and `err_o` are all 0.
- R2: A start pulse taken while the block is not busy raises `busy_o` in the next cycle. `req_o` then stays 0 for exactly `SETTLE_CYC` cycles and rises in the cycle after that.
- R3: While the request is high, the acknowledges are sampled at the end of every `POLL_CYC` cycles. The k-th sample is taken at the (k·`POLL_CYC`)-th clock edge after `req_o` rises. The handshake succeeds only when `ack_a_i` and `ack_b_i` are both 1 in the same sample. One acknowledge alone never counts.
- R4: Each acknowledge passes through two synchronizing flops. A level applied just after clock edge e is visible to a sample taken at edge e+3, and not to a sample taken at edge e+2.
- R5: At most `MAX_POLLS` samples are taken. If none of them succeeds, the handshake ends in a timeout. `done_o` then pulses `SETTLE_CYC` + `MAX_POLLS`·`POLL_CYC` cycles after the start edge, with `err_o` = 1.
- R6: `req_o` falls in the cycle in which `done_o` pulses, whether the handshake succeeded or timed out. `req_o` is never 1 while `busy_o` is 0.
- R7: `done_o` is high for exactly one cycle per handshake. `busy_o` is 0 in that cycle.
- R8: `err_o` is 0 after a success and 1 after a timeout. It keeps its value from the done cycle until the next accepted start, which clears it.
- R9: A start pulse that arrives while `busy_o` is 1 is ignored. The running handshake keeps its timing and produces a single done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that starts a handshake |
| ack_a_i | input | 1 | First acknowledge from the PLL control interface (asynchronous) |
| ack_b_i | input | 1 | Second acknowledge from the PLL control interface (asynchronous) |
| req_o | output | 1 | Control request to the PLL |
| busy_o | output | 1 | A handshake is in progress |
| done_o | output | 1 | One-cycle pulse when a handshake finishes |
| err_o | output | 1 | Result of the last handshake: 1 = timeout, 0 = success |

## Verification
The hardest case to reach from the ports is an acknowledge that changes right at the synchronizer's latency boundary before a sample. Whether that sample counts depends on a single cycle of timing. The bench counts clock edges from the start pulse and raises both acknowledges exactly three edges before a chosen sample, and in a second run exactly two edges before it. It expects the first run to finish at that sample and the second to finish one poll later. A second case that is easy to miss keeps one acknowledge high and the other low for every poll. That run must end in a timeout even though the interface looks half-answered.

// File: rtl/pllhs_pkg.sv
package pllhs_pkg;

  typedef enum logic [1:0] {
    HS_IDLE   = 2'd0,
    HS_SETTLE = 2'd1,
    HS_POLL   = 2'd2,
    HS_FINISH = 2'd3
  } hs_state_e;

endpackage

// File: rtl/pllhs_sync.sv
module pllhs_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], async_i[b]};
    end

    assign sync_o[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/pllhs_timer.sv
module pllhs_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/pllhs_poll_ctr.sv
module pllhs_poll_ctr #(
  parameter int MAX_POLLS = 100,
  parameter int PC_W      = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);

  logic [PC_W-1:0] polls_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      polls_q <= '0;
    else if (clr_i)   polls_q <= '0;
    else if (inc_i)   polls_q <= polls_q + 1'b1;
  end

  // Asserted while the sample about to be taken is the final permitted one
  assign last_o = (polls_q == PC_W'(MAX_POLLS - 1));

endmodule

// File: rtl/pll_ctl_handshake.sv
module pll_ctl_handshake
  import pllhs_pkg::*;
#(
  parameter int SETTLE_CYC  = 1000,
  parameter int POLL_CYC    = 1000,
  parameter int MAX_POLLS   = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic ack_a_i,
  input  logic ack_b_i,
  output logic req_o,
  output logic busy_o,
  output logic done_o,
  output logic err_o
);

  localparam int LONGEST = (SETTLE_CYC > POLL_CYC) ? SETTLE_CYC : POLL_CYC;
  localparam int CNT_W   = (LONGEST > 1) ? $clog2(LONGEST) : 1;
  localparam int PC_W    = $clog2(MAX_POLLS + 1);
  localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] POLL_LD   = CNT_W'(POLL_CYC - 1);

  hs_state_e        state_q, state_d;
  logic [1:0]       ack_sync;
  logic             ack_both;
  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic             poll_clr, poll_inc, poll_last;
  logic             err_q, err_set, err_clr;
  logic             start_take;

  pllhs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({ack_b_i, ack_a_i}),
    .sync_o  (ack_sync)
  );

  assign ack_both = &ack_sync;

  pllhs_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  pllhs_poll_ctr #(.MAX_POLLS(MAX_POLLS), .PC_W(PC_W)) u_polls (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (poll_clr),
    .inc_i  (poll_inc),
    .last_o (poll_last)
  );

  assign start_take = start_i && (state_q == HS_IDLE || state_q == HS_FINISH);

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    poll_clr = 1'b0;
    poll_inc = 1'b0;
    err_set  = 1'b0;
    err_clr  = 1'b0;
    unique case (state_q)
      HS_IDLE, HS_FINISH: begin
        state_d = HS_IDLE;
        if (start_take) begin
          state_d  = HS_SETTLE;
          tmr_load = 1'b1;
          tmr_val  = SETTLE_LD;
          poll_clr = 1'b1;
          err_clr  = 1'b1;
        end
      end
      HS_SETTLE: begin
        if (tmr_zero) begin
          state_d  = HS_POLL;
          tmr_load = 1'b1;
          tmr_val  = POLL_LD;
        end
      end
      HS_POLL: begin
        if (tmr_zero) begin
          if (ack_both) begin
            state_d = HS_FINISH;
          end else if (poll_last) begin
            state_d = HS_FINISH;
            err_set = 1'b1;
          end else begin
            poll_inc = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = POLL_LD;
          end
        end
      end
      default: state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= HS_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      err_q <= 1'b0;
    else if (err_clr) err_q <= 1'b0;
    else if (err_set) err_q <= 1'b1;
  end

  assign req_o  = (state_q == HS_POLL);
  assign busy_o = (state_q == HS_SETTLE) || (state_q == HS_POLL);
  assign done_o = (state_q == HS_FINISH);
  assign err_o  = err_q;

endmodule

// File: rtl/pll_ctl_handshake_chk.sv
module pll_ctl_handshake_chk #(
  parameter int SETTLE_CYC = 1000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic req_o,
  input logic busy_o,
  input logic done_o,
  input logic err_o
);

  localparam int SW = $clog2(SETTLE_CYC + 2) + 1;

  // Counts cycles spent busy with the request still low since the start
  logic [SW-1:0] low_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 low_cnt_q <= '0;
    else if (!busy_o)            low_cnt_q <= '0;
    else if (!req_o && (low_cnt_q != '1)) low_cnt_q <= low_cnt_q + 1'b1;
  end

  p_settle_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> (low_cnt_q == SW'(SETTLE_CYC)));

  p_req_within_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> busy_o);

  p_req_drops_at_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(req_o) && !req_o));

  p_done_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_not_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_err_held_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !$past(busy_o)) |-> $stable(err_o));

  p_no_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));

endmodule

bind pll_ctl_handshake pll_ctl_handshake_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .req_o   (req_o),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .err_o   (err_o)
);

// File: tb/pll_ctl_handshake_tb.sv
module pll_ctl_handshake_tb;

  localparam int S = 5;
  localparam int P = 4;
  localparam int M = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic ack_a = 1'b0;
  logic ack_b = 1'b0;
  logic req, busy, done, err;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pll_ctl_handshake #(
    .SETTLE_CYC(S), .POLL_CYC(P), .MAX_POLLS(M), .SYNC_STAGES(2)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .ack_a_i(ack_a), .ack_b_i(ack_b),
    .req_o(req), .busy_o(busy), .done_o(done), .err_o(err)
  );

  task automatic chk(input string what, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%b expected=%b (t=%0t)", what, act, exp, $time);
    end
  endtask

  // Pulse start; return at the negedge after the accepting edge (offset 0)
  task automatic kick();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic adv(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 req after reset", req, 1'b0);
    chk("R1 busy after reset", busy, 1'b0);
    chk("R1 done after reset", done, 1'b0);
    chk("R1 err after reset", err, 1'b0);
  endtask

  task automatic t_first_poll();
    ack_a = 1'b1; ack_b = 1'b1;
    adv(4);
    kick();
    chk("R2 busy at start", busy, 1'b1);
    chk("R2 req low at start", req, 1'b0);
    adv(S - 1);
    chk("R2 req low at end of settle", req, 1'b0);
    adv(1);
    chk("R2 req rises after settle", req, 1'b1);
    adv(P - 1);
    chk("R3 no done before first sample", done, 1'b0);
    adv(1);
    chk("R3 done at first sample", done, 1'b1);
    chk("R8 err zero on success", err, 1'b0);
    chk("R6 req low at done", req, 1'b0);
    chk("R7 busy low at done", busy, 1'b0);
    adv(1);
    chk("R7 done one cycle", done, 1'b0);
    ack_a = 1'b0; ack_b = 1'b0;
    adv(4);
  endtask

  task automatic t_third_poll();
    kick();
    adv(S + 2 * P);
    chk("R3 no done after failed sample 2", done, 1'b0);
    ack_a = 1'b1; ack_b = 1'b1;
    adv(P);
    chk("R3 done at sample 3", done, 1'b1);
    chk("R8 err zero at sample 3", err, 1'b0);
    ack_a = 1'b0; ack_b = 1'b0;
    adv(4);
  endtask

  task automatic t_sync_edge(input int lead, input bit seen);
    kick();
    adv(S + 3 * P - lead);
    ack_a = 1'b1; ack_b = 1'b1;
    adv(lead);
    chk("R4 sample 3 vs sync latency", done, seen);
    if (!seen) begin
      adv(P);
      chk("R4 seen at sample 4", done, 1'b1);
    end
    ack_a = 1'b0; ack_b = 1'b0;
    adv(4);
  endtask

  task automatic t_timeout_one_ack();
    ack_a = 1'b1; ack_b = 1'b0;
    kick();
    adv(S + M * P - 1);
    chk("R5 still polling before limit", done, 1'b0);
    chk("R5 req high before limit", req, 1'b1);
    adv(1);
    chk("R5 done at poll limit", done, 1'b1);
    chk("R5 err on timeout", err, 1'b1);
    chk("R6 req dropped after timeout", req, 1'b0);
    adv(3);
    chk("R8 err held while idle", err, 1'b1);
    chk("R7 no further done", done, 1'b0);
    ack_a = 1'b1; ack_b = 1'b1;
    adv(3);
    kick();
    chk("R8 err cleared by start", err, 1'b0);
    adv(S + P);
    chk("R8 success after timeout", done, 1'b1);
    chk("R8 err zero after success", err, 1'b0);
    ack_a = 1'b0; ack_b = 1'b0;
    adv(4);
  endtask

  task automatic t_start_while_busy();
    kick();
    adv(S + 1);
    start = 1'b1;
    adv(1);
    start = 1'b0;
    chk("R9 req kept high after stray start", req, 1'b1);
    chk("R9 still busy", busy, 1'b1);
    adv(2 * P - 2);
    ack_a = 1'b1; ack_b = 1'b1;
    adv(P - 1);
    chk("R9 no early done", done, 1'b0);
    adv(1);
    chk("R9 done on original schedule", done, 1'b1);
    adv(1);
    chk("R9 single done pulse", done, 1'b0);
    chk("R9 idle after done", busy, 1'b0);
    ack_a = 1'b0; ack_b = 1'b0;
    adv(4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    adv(2);
    t_reset();
    t_first_poll();
    t_third_poll();
    t_sync_edge(3, 1'b1);
    t_sync_edge(2, 1'b0);
    t_timeout_one_ack();
    t_start_while_busy();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule